// File: doc/BRIEF.md
# Ratio-Controlled PWM Duty Generator

This block drives the switching transistor of one bridge leg with a fixed-frequency pulse train. The on-duty follows the ratio of two digitized voltages: a setting code and a measured supply code. The pulse therefore holds a set average voltage across the load while the supply drifts. A free-running carrier counter sets the period. The number of clock cycles in the period comes from a clock-frequency parameter and a carrier-frequency parameter, 25 kHz by default.

Both codes are sampled into holding registers when `code_valid` pulses. The setting code is raised to a floor code that stands for 3 V. At each carrier boundary a sequential divider is started on the held codes. It produces the on-cycle count, which is loaded at the following boundary, so a period never changes its threshold partway through. `pwm_on` is high during the on-phase and turns on the low-side switch of the leg. During the off-phase the leg is released to high impedance and the opposite high side stays on. Both of those are handled outside this block.

Codes are in units of 100 mV. With the defaults, a code of 120 is 12 V and the floor code is 30.

Top module: `pwm_ratio_duty_gen`

## Requirements
- R1: While `enable` is high, `period_start` is a single-cycle pulse every PERIOD = CLK_HZ / CARRIER_HZ cycles, which is 2000 at 50 MHz and 25 kHz.
- R2: The number of `pwm_on` cycles in a period is floor(ref × PERIOD / sup). For example, ref 90 and sup 120 give 1500 cycles (75 %).
- R3: A setting code below FLOOR_CODE (30) is replaced by FLOOR_CODE before the division. Ref 10 with sup 120 gives 500 cycles.
- R4: When the effective setting code is greater than or equal to the supply code, `pwm_on` is high for all PERIOD cycles.
- R5: A supply code of zero gives zero on-cycles, whatever the setting code is.
- R6: Within each period the on-phase is one contiguous run that starts one cycle after `period_start`. Codes strobed during period N take effect in period N+2. The threshold never changes except at a boundary.
- R7: When `enable` is low, `pwm_on` is low from the next clock edge and the carrier counter returns to zero. When `enable` rises again, `period_start` is asserted in that same cycle.
- R8: Changes on the code inputs have no effect unless `code_valid` is high.
- R9: During reset `pwm_on` is low. After reset, with no codes strobed, the duty is zero.
- R10: The divider always finishes before the next carrier boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the carrier; low forces the output off |
| vref_code | input | CODE_W | Setting voltage code |
| vsup_code | input | CODE_W | Measured supply voltage code |
| code_valid | input | 1 | Sample both codes this cycle |
| pwm_on | output | 1 | Active-high on-phase for the low-side switch |
| period_start | output | 1 | First cycle of each carrier period |

## Verification
The hardest case to reach is a code update that lands in the middle of a period. Three things must hold together: the running period keeps its old on-run, the period after it is still old, and the new run appears only two boundaries later. The bench measures one period and, partway through it, drives new codes with `code_valid` on chosen sample cycles. It then checks the whole on/off pattern, cycle by cycle, for both that period and a later one. Saturation, zero supply and the floor clamp are reached through table vectors whose expected counts are written alongside them.

// File: rtl/pwm_ratio_pkg.sv
// Shared types for the ratio-controlled PWM generator.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package pwm_ratio_pkg;
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;
endpackage

// File: rtl/pwm_code_latch.sv
// Holds the setting and supply codes sampled on code_valid and raises the
// setting code to a floor before it reaches the divider.
// Assumes: codes are stable in the cycle code_valid is high.
module pwm_code_latch #(
    parameter int CODE_W     = 8,
    parameter int FLOOR_CODE = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] vref_in,
    input  logic [CODE_W-1:0] vsup_in,
    output logic [CODE_W-1:0] vref_eff,
    output logic [CODE_W-1:0] vsup_held
);
    logic [CODE_W-1:0] ref_q;

    // Capture both codes only when the strobe is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= '0;
            vsup_held <= '0;
        end else if (code_valid) begin
            ref_q     <= vref_in;
            vsup_held <= vsup_in;
        end
    end

    // Raise a setting below the usable floor up to the floor.
    always_comb begin
        vref_eff = (ref_q < CODE_W'(FLOOR_CODE)) ? CODE_W'(FLOOR_CODE) : ref_q;
    end

    // R8: without the strobe the held codes keep their value.
    assert_hold_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> ($stable(ref_q) && $stable(vsup_held)));
endmodule

// File: rtl/pwm_ratio_div.sv
// Computes the on-cycle count floor(num * PERIOD / den) with a restoring
// divider that retires one quotient bit per clock. Saturated and zero
// cases finish at once. Result is held until the next start.
// Assumes: start comes no more often than once per PERIOD cycles, which is
// far longer than NUM_W cycles.
module pwm_ratio_div
    import pwm_ratio_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int PERIOD = 2000,
    parameter int Q_W    = 11,
    parameter int NUM_W  = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] num_code,
    input  logic [CODE_W-1:0] den_code,
    output logic [Q_W-1:0]    quot
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    div_state_t        state;
    logic [CODE_W:0]   rem;
    logic [CODE_W:0]   rem_sh;
    logic [CODE_W:0]   rem_nx;
    logic [NUM_W-1:0]  acc;
    logic [NUM_W-1:0]  acc_nx;
    logic [CODE_W-1:0] den_q;
    logic [STEP_W-1:0] step;
    logic              fits;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        rem_sh = {rem[CODE_W-1:0], acc[NUM_W-1]};
        fits   = (rem_sh >= {1'b0, den_q});
        rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
        acc_nx = {acc[NUM_W-2:0], fits};
    end

    // Sequencer: launch, iterate NUM_W steps, publish the quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DIV_IDLE;
            rem   <= '0;
            acc   <= '0;
            den_q <= '0;
            step  <= '0;
            quot  <= '0;
        end else if (state == DIV_IDLE) begin
            if (start) begin
                if (den_code == '0) begin
                    quot <= '0;
                end else if (num_code >= den_code) begin
                    quot <= Q_W'(PERIOD);
                end else begin
                    acc   <= NUM_W'(num_code) * NUM_W'(PERIOD);
                    rem   <= '0;
                    den_q <= den_code;
                    step  <= '0;
                    state <= DIV_RUN;
                end
            end
        end else begin
            rem  <= rem_nx;
            acc  <= acc_nx;
            step <= step + 1'b1;
            if (step == STEP_W'(NUM_W - 1)) begin
                quot  <= acc_nx[Q_W-1:0];
                state <= DIV_IDLE;
            end
        end
    end

    // R10: a boundary never finds the divider still working.
    assert_ready_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == DIV_IDLE));
    // R4: the published count never exceeds one full period.
    assert_quot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        quot <= Q_W'(PERIOD));
endmodule

// File: rtl/pwm_carrier.sv
// Free-running carrier counter; marks the first cycle of each period.
// Assumes: PERIOD >= 2. Counter is held at zero while enable is low.
module pwm_carrier #(
    parameter int PERIOD = 2000,
    parameter int CNT_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    output logic [CNT_W-1:0] cnt,
    output logic             period_start
);
    // Count 0..PERIOD-1 while running, park at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Boundary marker for the first cycle of a period.
    always_comb begin
        period_start = enable && (cnt == '0);
    end

    // R1: the counter stays inside one period.
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(PERIOD));
    // R7: a disable always returns the counter to zero.
    assert_cnt_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0));
endmodule

// File: rtl/pwm_ratio_duty_gen.sv
// Top level: PWM whose on-duty is the ratio of a setting code to a supply
// code, updated only at carrier boundaries. pwm_on is registered.
// Assumes: codes in a common unit; FLOOR_CODE expresses the lowest usable
// setting in that unit.
module pwm_ratio_duty_gen #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int CARRIER_HZ = 25_000,
    parameter int CODE_W     = 8,
    parameter int FLOOR_CODE = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CODE_W-1:0] vref_code,
    input  logic [CODE_W-1:0] vsup_code,
    input  logic              code_valid,
    output logic              pwm_on,
    output logic              period_start
);
    localparam int PERIOD = CLK_HZ / CARRIER_HZ;
    localparam int CNT_W  = $clog2(PERIOD + 1);
    localparam int NUM_W  = CODE_W + CNT_W;

    logic [CODE_W-1:0] vref_eff;
    logic [CODE_W-1:0] vsup_held;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  div_q;
    logic [CNT_W-1:0]  thr_q;
    logic [CNT_W-1:0]  thr_cur;

    pwm_code_latch #(.CODE_W(CODE_W), .FLOOR_CODE(FLOOR_CODE)) u_codes (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_valid (code_valid),
        .vref_in    (vref_code),
        .vsup_in    (vsup_code),
        .vref_eff   (vref_eff),
        .vsup_held  (vsup_held)
    );

    pwm_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .cnt          (cnt),
        .period_start (period_start)
    );

    pwm_ratio_div #(.CODE_W(CODE_W), .PERIOD(PERIOD), .Q_W(CNT_W), .NUM_W(NUM_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (period_start),
        .num_code (vref_eff),
        .den_code (vsup_held),
        .quot     (div_q)
    );

    // Threshold in force this cycle; a boundary takes the fresh quotient.
    always_comb begin
        thr_cur = period_start ? div_q : thr_q;
    end

    // Load the threshold only at carrier boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (period_start) begin
            thr_q <= div_q;
        end
    end

    // Registered on-phase: high for the first thr_cur counts of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_on <= 1'b0;
        end else begin
            pwm_on <= enable && (cnt < thr_cur);
        end
    end

    // R7: disable turns the output off at the next edge.
    assert_off_after_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pwm_on);
    // R6: the threshold moves only right after a boundary.
    assert_thr_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(thr_q) |-> $past(period_start));
    // R5: a zero-supply result holds the output off through the period.
    assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q == '0 && !period_start) |=> !pwm_on);
endmodule

// File: tb/tb_pwm_ratio_duty_gen.sv
module tb_pwm_ratio_duty_gen;
    localparam int P  = 2000;
    localparam int NV = 10;
    // {setting code, supply code, expected on-cycles, requirement tag}
    localparam int VEC [NV][4] = '{
        '{ 90, 120, 1500, 2},
        '{ 60, 120, 1000, 2},
        '{ 77, 200,  770, 2},
        '{ 31,  97,  639, 2},
        '{ 10, 120,  500, 3},
        '{ 29,  30, 2000, 3},
        '{200, 120, 2000, 4},
        '{120, 120, 2000, 4},
        '{ 50,   0,    0, 5},
        '{100, 255,  784, 2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] vref_code = '0;
    logic [7:0] vsup_code = '0;
    logic       code_valid = 1'b0;
    logic       pwm_on;
    logic       period_start;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    pwm_ratio_duty_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .vref_code    (vref_code),
        .vsup_code    (vsup_code),
        .code_valid   (code_valid),
        .pwm_on       (pwm_on),
        .period_start (period_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ps();
        forever begin
            @(negedge clk);
            if (period_start) break;
        end
    endtask

    task automatic apply(input int r, input int s);
        @(negedge clk);
        vref_code  = 8'(r);
        vsup_code  = 8'(s);
        code_valid = 1'b1;
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    // Measure one period; optionally strobe new codes at sample chg_at.
    task automatic measure(input bit wait_first, input int exp, input string req,
                           input int chg_at, input int cr, input int cs);
        int on = 0;
        int bad = 0;
        int psbad = 0;
        if (wait_first) wait_ps();
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (i == chg_at) begin
                vref_code = 8'(cr); vsup_code = 8'(cs); code_valid = 1'b1;
            end else if (i == chg_at + 1) begin
                code_valid = 1'b0;
            end
            if (pwm_on) on++;
            if (pwm_on != (i < exp)) bad++;
            if (period_start != (i == P - 1)) psbad++;
        end
        check(on == exp, req, on, exp);
        check(bad == 0, {req, " R6 contiguous run"}, bad, 0);
        check(psbad == 0, {req, " R1 period length"}, psbad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (4) @(negedge clk);
        check(pwm_on == 1'b0, "R9 pwm_on in reset", int'(pwm_on), 0);
        check(period_start == 1'b0, "R9 period_start in reset", int'(period_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        measure(1'b1, 0, "R9 duty after reset", -5, 0, 0);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][0], VEC[v][1]);
            wait_ps();
            measure(1'b1, VEC[v][2], $sformatf("R%0d vector %0d", VEC[v][3], v), -5, 0, 0);
        end

        // R6: mid-period strobe keeps this and the next period, lands two later
        measure(1'b1, 784, "R6 period with mid strobe", 700, 90, 120);
        measure(1'b0, 784, "R6 period after strobe", -5, 0, 0);
        measure(1'b1, 1500, "R6 new duty two boundaries later", -5, 0, 0);

        // R8: code change without strobe is ignored
        @(negedge clk);
        vref_code = 8'd10;
        vsup_code = 8'd200;
        wait_ps();
        wait_ps();
        measure(1'b1, 1500, "R8 unstrobed codes ignored", -5, 0, 0);

        // R7: disable during the on-phase
        wait_ps();
        repeat (10) @(negedge clk);
        check(pwm_on == 1'b1, "R7 on before disable", int'(pwm_on), 1);
        enable = 1'b0;
        @(negedge clk);
        check(pwm_on == 1'b0, "R7 off one clock after disable", int'(pwm_on), 0);
        check(period_start == 1'b0, "R7 no boundary while disabled", int'(period_start), 0);
        repeat (50) @(negedge clk);
        check(pwm_on == 1'b0, "R7 stays off while disabled", int'(pwm_on), 0);
        enable = 1'b1;
        #1;
        check(period_start == 1'b1, "R7 boundary on re-enable", int'(period_start), 1);
        measure(1'b0, 1500, "R7 first period after re-enable", -5, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule